// File: doc/BRIEF.md
# Burst-Mode Radio Transmit Sequencer

This block drains a telemetry payload FIFO in periodic bursts so that the radio can be powered only when it is needed. A countdown timer marks a burst slot once every `period_i` clock cycles. At each slot with data waiting, the block switches on the frequency synthesizer. If the synthesizer was off, it first waits `settle_i` cycles for it to lock. It then raises the power-amplifier enable and shifts out one packet, one bit per clock. The packet is a training preamble, then a header holding a sequence number and the word count, then the payload words taken from the FIFO.

After the last payload bit the block spends one shutdown cycle and decides what to do with the synthesizer. If a full start-up fits in the cycles left before the next slot, the synthesizer is turned off. Otherwise it stays on, and the next burst starts without any settling wait. A slot that finds the FIFO empty sends nothing and leaves both enables low. The FIFO is show-ahead: `fifo_data_i` always presents the oldest word, and each `fifo_pop_o` pulse consumes it.

Top module: `bmt_burst_tx`

## Requirements
- R1: While `rst_ni` is low, `synth_en_o`, `pa_en_o`, `tx_valid_o`, `fifo_pop_o` and `tx_bit_o` are 0. The first burst slot falls in the cycle in which reset is released.
- R2: Burst slots occur in every cycle whose index since reset release is a multiple of `period_i` (`period_i` >= 2).
- R3: At a slot where `fifo_level_i` is 0, no packet is sent. In the next cycle `synth_en_o` and `pa_en_o` are 0, and the sequence number is unchanged.
- R4: At a slot with data where the synthesizer is off, `synth_en_o` rises in the next cycle. `tx_valid_o` first rises `settle_i` cycles after that (`settle_i` >= 1).
- R5: At a slot with data where the synthesizer is already on, `tx_valid_o` rises in the cycle right after the slot.
- R6: A packet is exactly 48 + 8·N bits, sent MSB first, one bit per cycle while `tx_valid_o` is 1. Bits 0..15 are the pattern 16'hAAAA. Bits 16..31 are the sync word 16'hE25A. Bits 32..39 are the sequence number. Bits 40..47 are N. The payload words follow, each 8 bits.
- R7: N equals `fifo_level_i` in the slot cycle. Words pushed after the slot wait for a later burst.
- R8: `fifo_pop_o` pulses exactly N times per packet, and only while `tx_valid_o` is 1. The first pulse comes in the last header bit cycle, and each later pulse comes in the last bit cycle of the previous word.
- R9: The sequence number starts at 0 after reset and increments by one, modulo 256, after each packet that is sent.
- R10: In the cycle after the last packet bit, `synth_en_o` is still 1. In the cycle after that, it is 0 if the number of cycles from that cycle to the next slot is at least `settle_i`, and 1 otherwise.
- R11: `pa_en_o` equals `tx_valid_o` in every cycle, and `pa_en_o` implies `synth_en_o`. `tx_bit_o` is 0 whenever `tx_valid_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, one transmitted bit per cycle |
| rst_ni | input | 1 | Active-low asynchronous reset |
| period_i | input | 20 | Burst slot spacing in cycles |
| settle_i | input | 20 | Synthesizer start-up time in cycles |
| fifo_level_i | input | 8 | Payload FIFO occupancy in words |
| fifo_data_i | input | 8 | Oldest FIFO word (show-ahead) |
| fifo_pop_o | output | 1 | Consume the oldest FIFO word |
| synth_en_o | output | 1 | Frequency synthesizer enable |
| pa_en_o | output | 1 | Power amplifier enable |
| tx_valid_o | output | 1 | Bit stream qualifier toward the modulator |
| tx_bit_o | output | 1 | Serial packet bit |

## Verification
The assertions take for granted that `period_i` and `settle_i` stay fixed between resets. They also assume that the settling time plus the longest packet plus the shutdown cycle ends before the next slot, so no slot ever arrives while a burst is in progress, and that occupancy never exceeds what the length field can hold. The stimulus picks a period first and then draws the settling time from the range that this bound leaves. It caps the bench FIFO at 20 words and changes configuration only while reset is held. Across phases the settling time runs from one cycle to close to the idle gap, so both the power-down and the keep-on decisions after a packet are reached.

// File: rtl/bmt_pkg.sv
package bmt_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETTLE,
    ST_PREAMBLE,
    ST_HEADER,
    ST_PAYLOAD,
    ST_SHUTDOWN
  } bmt_state_e;

  localparam int unsigned TRAIN_W  = 16;
  localparam logic [TRAIN_W-1:0] ALT_WORD = 16'hAAAA;
endpackage

// File: rtl/bmt_burst_timer.sv
module bmt_burst_timer #(
  parameter int unsigned TIME_W = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [TIME_W-1:0] period_i,
  output logic              due_o,
  output logic [TIME_W-1:0] remain_o
);
  logic [TIME_W-1:0] cnt_q;

  // counts down to the slot; slot in the cycle where count is zero
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (cnt_q == '0) cnt_q <= period_i - TIME_W'(1);
    else                  cnt_q <= cnt_q - TIME_W'(1);
  end

  assign due_o    = (cnt_q == '0);
  assign remain_o = cnt_q;

  assert_reload_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    due_o |=> (remain_o == $past(period_i) - TIME_W'(1)));
endmodule

// File: rtl/bmt_shifter.sv
module bmt_shifter #(
  parameter int unsigned SH_W = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic [SH_W-1:0] load_val_i,
  input  logic            shift_i,
  output logic            msb_o
);
  logic [SH_W-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sh_q <= '0;
    else if (load_i)  sh_q <= load_val_i;
    else if (shift_i) sh_q <= {sh_q[SH_W-2:0], 1'b0};
  end

  assign msb_o = sh_q[SH_W-1];
endmodule

// File: rtl/bmt_burst_tx.sv
module bmt_burst_tx
  import bmt_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned LEN_W  = 8,
  parameter int unsigned SEQ_W  = 8,
  parameter int unsigned TIME_W = 20,
  parameter logic [15:0] SYNC_WORD = 16'hE25A
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [TIME_W-1:0] period_i,
  input  logic [TIME_W-1:0] settle_i,
  input  logic [LEN_W-1:0]  fifo_level_i,
  input  logic [DATA_W-1:0] fifo_data_i,
  output logic              fifo_pop_o,
  output logic              synth_en_o,
  output logic              pa_en_o,
  output logic              tx_valid_o,
  output logic              tx_bit_o
);
  localparam int unsigned PRE_W  = 2 * TRAIN_W;
  localparam int unsigned HDR_W  = SEQ_W + LEN_W;
  localparam int unsigned MAX_A  = (PRE_W > HDR_W) ? PRE_W : HDR_W;
  localparam int unsigned SH_W   = (MAX_A > DATA_W) ? MAX_A : DATA_W;
  localparam int unsigned BCNT_W = $clog2(SH_W);

  bmt_state_e        state_q;
  logic              synth_q;
  logic [TIME_W-1:0] settle_cnt_q;
  logic [BCNT_W-1:0] bcnt_q;
  logic [LEN_W-1:0]  len_q, left_q;
  logic [SEQ_W-1:0]  seq_q;

  logic              due;
  logic [TIME_W-1:0] remain;
  logic              in_pkt, start, pre_load, hdr_load, word_end, pay_load, sh_load, msb;
  logic [SH_W-1:0]   load_val;

  bmt_burst_timer #(.TIME_W(TIME_W)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .period_i(period_i),
    .due_o   (due),
    .remain_o(remain)
  );

  assign in_pkt   = (state_q == ST_PREAMBLE) || (state_q == ST_HEADER) || (state_q == ST_PAYLOAD);
  assign start    = (state_q == ST_IDLE) && due && (fifo_level_i != '0);
  assign pre_load = (start && synth_q) ||
                    ((state_q == ST_SETTLE) && (settle_cnt_q <= TIME_W'(1)));
  assign hdr_load = (state_q == ST_PREAMBLE) && (bcnt_q == BCNT_W'(PRE_W - 1));
  assign word_end = (state_q == ST_PAYLOAD) && (bcnt_q == BCNT_W'(DATA_W - 1));
  assign pay_load = ((state_q == ST_HEADER) && (bcnt_q == BCNT_W'(HDR_W - 1))) ||
                    (word_end && (left_q != '0));
  assign sh_load  = pre_load || hdr_load || pay_load;

  always_comb begin
    if (pre_load)      load_val = SH_W'({ALT_WORD, SYNC_WORD}) << (SH_W - PRE_W);
    else if (hdr_load) load_val = SH_W'({seq_q, len_q}) << (SH_W - HDR_W);
    else               load_val = SH_W'(fifo_data_i) << (SH_W - DATA_W);
  end

  bmt_shifter #(.SH_W(SH_W)) u_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (sh_load),
    .load_val_i(load_val),
    .shift_i   (in_pkt),
    .msb_o     (msb)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      synth_q      <= 1'b0;
      settle_cnt_q <= '0;
      bcnt_q       <= '0;
      len_q        <= '0;
      left_q       <= '0;
      seq_q        <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (due) begin
            if (fifo_level_i == '0) begin
              synth_q <= 1'b0;
            end else begin
              len_q  <= fifo_level_i;
              bcnt_q <= '0;
              if (synth_q) begin
                state_q <= ST_PREAMBLE;
              end else begin
                state_q      <= ST_SETTLE;
                synth_q      <= 1'b1;
                settle_cnt_q <= settle_i;
              end
            end
          end
        end
        ST_SETTLE: begin
          if (settle_cnt_q <= TIME_W'(1)) state_q <= ST_PREAMBLE;
          else settle_cnt_q <= settle_cnt_q - TIME_W'(1);
        end
        ST_PREAMBLE: begin
          if (hdr_load) begin
            state_q <= ST_HEADER;
            bcnt_q  <= '0;
          end else bcnt_q <= bcnt_q + BCNT_W'(1);
        end
        ST_HEADER: begin
          if (pay_load) begin
            state_q <= ST_PAYLOAD;
            bcnt_q  <= '0;
            left_q  <= len_q - LEN_W'(1);
          end else bcnt_q <= bcnt_q + BCNT_W'(1);
        end
        ST_PAYLOAD: begin
          if (word_end) begin
            bcnt_q <= '0;
            if (left_q == '0) state_q <= ST_SHUTDOWN;
            else left_q <= left_q - LEN_W'(1);
          end else bcnt_q <= bcnt_q + BCNT_W'(1);
        end
        ST_SHUTDOWN: begin
          seq_q   <= seq_q + SEQ_W'(1);
          state_q <= ST_IDLE;
          // power down only if a full start-up fits before the next slot
          if (remain >= settle_i) synth_q <= 1'b0;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign fifo_pop_o = pay_load;
  assign synth_en_o = synth_q;
  assign pa_en_o    = in_pkt;
  assign tx_valid_o = in_pkt;
  assign tx_bit_o   = in_pkt & msb;

  assert_pa_synth_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pa_en_o |-> synth_en_o);
  assert_skip_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == ST_IDLE) && due && (fifo_level_i == '0)) |=> (!synth_en_o && !pa_en_o));
  assert_settle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SETTLE) |-> (synth_en_o && !pa_en_o));
  assert_pop_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_pop_o |-> tx_valid_o);
  assert_len_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> (len_q == $past(fifo_level_i)));
  assert_seq_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SHUTDOWN) |=> (seq_q == $past(seq_q) + SEQ_W'(1)));
  assert_keep_on_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == ST_SHUTDOWN) && (remain < settle_i)) |=> synth_en_o);
endmodule

// File: tb/tb_bmt_burst_tx.sv
module tb_bmt_burst_tx;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] SYNC = 16'hE25A;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [19:0] period_i = 20'd300;
  logic [19:0] settle_i = 20'd1;
  logic [7:0]  fifo_level_i, fifo_data_i;
  logic        fifo_pop_o, synth_en_o, pa_en_o, tx_valid_o, tx_bit_o;

  logic [7:0]  mem [256];
  logic [31:0] rd_ptr, wr_ptr;
  int          n_chk = 0, n_bad = 0, cyc = 0;
  bit          mon_on = 0, done = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  assign fifo_level_i = 8'(wr_ptr - rd_ptr);
  assign fifo_data_i  = mem[rd_ptr[7:0]];

  always @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) rd_ptr <= 0;
    else if (fifo_pop_o) rd_ptr <= rd_ptr + 1;

  always @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) cyc <= 0;
    else cyc <= cyc + 1;

  bmt_burst_tx dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .period_i(period_i), .settle_i(settle_i),
    .fifo_level_i(fifo_level_i), .fifo_data_i(fifo_data_i), .fifo_pop_o(fifo_pop_o),
    .synth_en_o(synth_en_o), .pa_en_o(pa_en_o), .tx_valid_o(tx_valid_o), .tx_bit_o(tx_bit_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
    end
  endtask

  function automatic logic exp_bit(input int i, input logic [7:0] seq,
                                   input logic [7:0] len, input logic [31:0] start);
    logic [7:0] w;
    if (i < 16) return logic'(16'hAAAA >> (15 - i));
    if (i < 32) return SYNC[31 - i];
    if (i < 40) return seq[39 - i];
    if (i < 48) return len[47 - i];
    w = mem[8'(start + 32'((i - 48) / 8))];
    return w[7 - ((i - 48) % 8)];
  endfunction

  // monitor state
  bit          pend, pend_on, prev_valid, shut_exp;
  int          pend_d, skip_at, shut_at, nbits, pops, bad_pre, bad_seq, bad_len, bad_pay;
  logic [7:0]  pend_len, seq_exp;
  logic [31:0] pend_start;

  always @(negedge clk_i) begin
    if (rst_ni && mon_on) begin
      chk(pa_en_o == tx_valid_o, "R11", pa_en_o, tx_valid_o);
      if (pa_en_o) chk(synth_en_o, "R11", synth_en_o, 1);
      if (!tx_valid_o) chk(tx_bit_o == 1'b0, "R11", tx_bit_o, 0);
      if (fifo_pop_o) chk(tx_valid_o, "R8", tx_valid_o, 1);
      if (skip_at == cyc) begin
        chk(!synth_en_o, "R3", synth_en_o, 0);
        chk(!pa_en_o, "R3", pa_en_o, 0);
      end
      if (shut_at == cyc) chk(synth_en_o == shut_exp, "R10", synth_en_o, shut_exp);
      if (pend && cyc == pend_d + 1) chk(synth_en_o, "R4", synth_en_o, 1);
      // R2: slots fall on multiples of the period
      if ((cyc % int'(period_i)) == 0 && !pend && !tx_valid_o) begin
        if (fifo_level_i == 0) skip_at = cyc + 1;
        else begin
          pend = 1; pend_d = cyc; pend_len = fifo_level_i;
          pend_start = rd_ptr; pend_on = synth_en_o;
        end
      end
      if (tx_valid_o && !prev_valid) begin
        int e;
        e = pend_d + 1 + (pend_on ? 0 : int'(settle_i));
        chk(pend && cyc == e, pend_on ? "R2,R5" : "R2,R4", cyc, e);
        nbits = 0; pops = 0; bad_pre = 0; bad_seq = 0; bad_len = 0; bad_pay = 0;
      end
      if (tx_valid_o) begin
        if (tx_bit_o !== exp_bit(nbits, seq_exp, pend_len, pend_start)) begin
          if (nbits < 32) bad_pre++;
          else if (nbits < 40) bad_seq++;
          else if (nbits < 48) bad_len++;
          else bad_pay++;
        end
        nbits++;
        if (fifo_pop_o) pops++;
      end
      if (!tx_valid_o && prev_valid) begin
        int dn;
        chk(nbits == 48 + 8 * int'(pend_len), "R6", nbits, 48 + 8 * int'(pend_len));
        chk(bad_pre == 0, "R6", bad_pre, 0);
        chk(bad_seq == 0, "R9", bad_seq, 0);
        chk(bad_len == 0, "R7", bad_len, 0);
        chk(bad_pay == 0, "R6", bad_pay, 0);
        chk(pops == int'(pend_len), "R8", pops, int'(pend_len));
        chk(synth_en_o, "R10", synth_en_o, 1);
        dn = ((cyc + int'(period_i) - 1) / int'(period_i)) * int'(period_i);
        shut_exp = (dn - cyc) < int'(settle_i);
        shut_at = cyc + 1;
        seq_exp = seq_exp + 8'd1;
        pend = 0;
      end
      prev_valid = tx_valid_o;
    end
  end

  task automatic run_phase(input int per, input int stl, input int pct,
                           input int prefill, input int ncyc);
    mon_on = 0;
    rst_ni = 1'b0;
    period_i = 20'(per);
    settle_i = 20'(stl);
    wr_ptr = 0;
    pend = 0; prev_valid = 0; skip_at = -1; shut_at = -1; seq_exp = 0;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    // R1: reset state
    chk(!synth_en_o && !pa_en_o && !tx_valid_o && !fifo_pop_o && !tx_bit_o, "R1",
        {synth_en_o, pa_en_o, tx_valid_o, fifo_pop_o, tx_bit_o}, 0);
    for (int k = 0; k < prefill; k++) begin
      mem[wr_ptr[7:0]] = 8'($urandom);
      wr_ptr = wr_ptr + 1;
    end
    @(posedge clk_i); #1;
    rst_ni = 1'b1;
    mon_on = 1;
    for (int c = 0; c < ncyc; c++) begin
      @(posedge clk_i); #1;
      if (int'($urandom % 100) < pct && (wr_ptr - rd_ptr) < 20) begin
        mem[wr_ptr[7:0]] = 8'($urandom);
        wr_ptr = wr_ptr + 1;
      end
    end
    mon_on = 0;
  endtask

  initial begin
    int per, stl;
    wr_ptr = 0;
    void'($urandom(32'd1234));
    run_phase(300, 1, 5, 3, 2400);     // shortest settle, first slot has data
    run_phase(400, 180, 3, 0, 3200);   // settle near idle gap: keep-on case
    run_phase(250, 20, 0, 0, 1000);    // empty FIFO: every slot skipped
    run_phase(500, 60, 10, 20, 4000);  // full-size packets
    for (int p = 0; p < 6; p++) begin
      per = 300 + int'($urandom % 400);
      stl = 1 + int'($urandom % (per - 215));
      run_phase(per, stl, 1 + int'($urandom % 8), int'($urandom % 5), per * 8);
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule